// File: doc/BRIEF.md
# Bit-Serial Dual-Basis GF(16) Multiplier

This block multiplies two symbols of the four-bit Galois field generated by the fixed polynomial x^4 + x + 1. The multiplicand arrives in ordinary polynomial form. A small XOR network turns it into its trace-dual coordinates. The block then loads those coordinates into a four-stage feedback shift register, and the register walks through the dual-coordinate sequence. The second operand is also taken in polynomial form. It is held in a register for the whole operation. Each output bit is the parity of the bitwise AND between the shift register and that held operand.

The block returns the product in dual coordinates, one bit per clock, starting from the highest index. Each bit is final in the cycle it appears, so the full product is out four cycles after the start edge and no flush cycle is needed. When the multiplicand port is tied to a constant, the conversion network reduces to fixed wiring. A caller may issue a new start in the cycle that carries the last bit, so streams can run back to back with no gap.

Top module: `gf16_dual_serial_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, prod_valid, prod_done, prod_bit and prod_idx are all zero.
- R2: A start seen at a clock edge while the block is idle is accepted. In the four cycles that follow, prod_valid is high and prod_idx reads 3, 2, 1, 0 in that order.
- R3: prod_done is high only in the cycle where prod_idx is 0 and prod_valid is high. If no new start is accepted at the next edge, prod_valid drops after that cycle.
- R4: Let a be mcand and b be mplier, where bit i of each is the coefficient of alpha^i. Let c = a*b reduced modulo x^4 + x + 1. The bit shown with index k is Tr(c * alpha^k), where Tr(x) = x + x^2 + x^4 + x^8.
- R5: Only the values of mcand and mplier present at the accepting edge are used. Changing them later does not alter the stream.
- R6: A start seen while prod_valid is high and prod_idx is not 0 is ignored, and the running stream continues unchanged.
- R7: A start seen at the edge that ends the done cycle is accepted. The next cycle then shows prod_valid high with prod_idx 3 and no idle cycle in between.
- R8: Whenever prod_valid is low, prod_bit and prod_idx are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Requests a new multiplication |
| mcand | input | 4 | Multiplicand in polynomial form; may be tied to a constant |
| mplier | input | 4 | Second operand in polynomial form |
| prod_bit | output | 1 | Current product bit in dual coordinates |
| prod_idx | output | 2 | Index of prod_bit, counting down from 3 |
| prod_valid | output | 1 | High while product bits are being presented |
| prod_done | output | 1 | Marks the last product bit |

## Verification
The hardest case to reach is a start that lands exactly at the edge closing the done cycle, combined with operands that change while a stream is running. Back-to-back starts test handover of the shift register and operand register with no gap. The exhaustive sweep over all 256 operand pairs varies the gap before each next start between none, one and two cycles. During every stream it inverts both operand ports. In half of the streams it also raises start in mid-stream. A per-cycle reference model predicts each bit, and every assembled product is mapped back to polynomial form and compared against a plain shift-and-reduce multiply.

// File: rtl/gf16_dual_pkg.sv
package gf16_dual_pkg;

    localparam int SYM_W = 4;
    localparam logic [SYM_W:0] FIELD_POLY = 5'b10011;
    localparam int IDX_W = $clog2(SYM_W);

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        sym_t             win;
        sym_t             opb;
    } mul_state_t;

    // multiply by alpha with reduction
    function automatic sym_t gf_xtime(sym_t x);
        sym_t r;
        r = {x[SYM_W-2:0], 1'b0};
        if (x[SYM_W-1]) r = r ^ FIELD_POLY[SYM_W-1:0];
        return r;
    endfunction

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t t;
        acc = '0;
        t   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xtime(t);
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(int n);
        sym_t x;
        x = sym_t'(1);
        for (int i = 0; i < n; i++) x = gf_xtime(x);
        return x;
    endfunction

    function automatic logic gf_trace(sym_t x);
        sym_t acc;
        sym_t y;
        acc = '0;
        y   = x;
        for (int i = 0; i < SYM_W; i++) begin
            acc = acc ^ y;
            y   = gf_mul(y, y);
        end
        return acc[0];
    endfunction

    // bit i = Tr(alpha^(n+i)); coordinate n of a is parity(a & mask)
    function automatic sym_t dual_mask(int n);
        sym_t m;
        for (int i = 0; i < SYM_W; i++) m[i] = gf_trace(gf_alpha_pow(n + i));
        return m;
    endfunction

endpackage

// File: rtl/gf16_dual_conv.sv
module gf16_dual_conv
    import gf16_dual_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic [W-1:0] poly_in,
    output logic [W-1:0] win_out
);
    // stage g holds dual coordinate (W-1+g), the highest window
    for (genvar g = 0; g < W; g++) begin : g_coord
        localparam sym_t MASK = dual_mask(W - 1 + g);
        assign win_out[g] = ^(poly_in & MASK[W-1:0]);
    end
endmodule

// File: rtl/gf16_dual_step.sv
module gf16_dual_step
    import gf16_dual_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic [W-1:0] win,
    input  logic [W-1:0] opb,
    output logic [W-1:0] win_nxt,
    output logic         bit_out
);
    logic [W-1:0] tap_term;

    // backwards recurrence: t(n) = t(n+W) ^ sum p_j t(n+j), j = 1..W-1
    assign tap_term[0] = win[W-1];
    for (genvar j = 1; j < W; j++) begin : g_tap
        if (FIELD_POLY[j]) begin : g_on
            assign tap_term[j] = win[j-1];
        end else begin : g_off
            assign tap_term[j] = 1'b0;
        end
    end

    assign win_nxt = {win[W-2:0], ^tap_term};
    assign bit_out = ^(win & opb);
endmodule

// File: rtl/gf16_dual_ctrl.sv
module gf16_dual_ctrl
    import gf16_dual_pkg::*;
#(
    parameter int W = SYM_W,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  load_win,
    input  logic [W-1:0]  opb_in,
    input  logic [W-1:0]  step_win,
    input  logic          step_bit,
    output logic [W-1:0]  win_q,
    output logic [W-1:0]  opb_q,
    output logic          prod_bit,
    output logic [IW-1:0] prod_idx,
    output logic          prod_valid,
    output logic          prod_done
);
    mul_state_t st_d, st_q;
    logic last_q;
    logic accept;

    assign last_q = st_q.busy && (st_q.idx == '0);
    assign accept = start && (!st_q.busy || last_q);

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.idx  = IW'(W - 1);
            st_d.win  = load_win;
            st_d.opb  = opb_in;
        end else if (last_q) begin
            st_d = '0;
        end else if (st_q.busy) begin
            st_d.idx = st_q.idx - IW'(1);
            st_d.win = step_win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_q      = st_q.win;
    assign opb_q      = st_q.opb;
    assign prod_valid = st_q.busy;
    assign prod_idx   = st_q.idx;
    assign prod_done  = last_q;
    assign prod_bit   = st_q.busy & step_bit;

    // R2
    accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (!prod_valid || prod_done)) |=> (prod_valid && prod_idx == IW'(W - 1)));
    // R2
    idx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && prod_idx != '0) |=> (prod_valid && prod_idx == $past(prod_idx) - IW'(1)));
    // R3
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_done && !start) |=> !prod_valid);
    // R5
    opb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && prod_idx != '0) |=> $stable(opb_q));
    // R4
    lfsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && prod_idx != '0) |=> (win_q[W-1:1] == $past(win_q[W-2:0])));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_valid |-> (!prod_bit && prod_idx == '0 && !prod_done));
endmodule

// File: rtl/gf16_dual_serial_mul.sv
module gf16_dual_serial_mul
    import gf16_dual_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SYM_W-1:0]      mcand,
    input  logic [SYM_W-1:0]      mplier,
    output logic                  prod_bit,
    output logic [IDX_W-1:0]      prod_idx,
    output logic                  prod_valid,
    output logic                  prod_done
);
    logic [SYM_W-1:0] load_win;
    logic [SYM_W-1:0] win_q;
    logic [SYM_W-1:0] opb_q;
    logic [SYM_W-1:0] step_win;
    logic             step_bit;

    gf16_dual_conv #(.W(SYM_W)) u_conv (
        .poly_in (mcand),
        .win_out (load_win)
    );

    gf16_dual_step #(.W(SYM_W)) u_step (
        .win     (win_q),
        .opb     (opb_q),
        .win_nxt (step_win),
        .bit_out (step_bit)
    );

    gf16_dual_ctrl #(.W(SYM_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .load_win   (load_win),
        .opb_in     (mplier),
        .step_win   (step_win),
        .step_bit   (step_bit),
        .win_q      (win_q),
        .opb_q      (opb_q),
        .prod_bit   (prod_bit),
        .prod_idx   (prod_idx),
        .prod_valid (prod_valid),
        .prod_done  (prod_done)
    );
endmodule

// File: tb/tb_gf16_dual_serial_mul.sv
module tb_gf16_dual_serial_mul;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] mcand = 4'd0;
    logic [3:0] mplier = 4'd0;
    logic       prod_bit;
    logic [1:0] prod_idx;
    logic       prod_valid;
    logic       prod_done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    gf16_dual_serial_mul dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .prod_bit(prod_bit), .prod_idx(prod_idx), .prod_valid(prod_valid), .prod_done(prod_done)
    );

    // reference arithmetic, shift-and-reduce with x^4 + x + 1
    function automatic int ref_mul(int a, int b);
        int r = 0;
        int x = a;
        for (int i = 0; i < 4; i++) begin
            if ((b >> i) & 1) r ^= x;
            x = x << 1;
            if (x & 16) x ^= 19;
        end
        return r;
    endfunction

    function automatic int ref_trace(int x);
        int acc = 0;
        int y = x;
        for (int i = 0; i < 4; i++) begin
            acc ^= y;
            y = ref_mul(y, y);
        end
        return acc & 1;
    endfunction

    function automatic int dual_bit(int c, int k);
        int ak = 1;
        for (int i = 0; i < k; i++) ak = ref_mul(ak, 2);
        return ref_trace(ref_mul(c, ak));
    endfunction

    function automatic int dual_to_poly(int bits);
        int found = -1;
        for (int c = 0; c < 16; c++) begin
            int ok = 1;
            for (int k = 0; k < 4; k++)
                if (dual_bit(c, k) != ((bits >> k) & 1)) ok = 0;
            if (ok != 0 && found < 0) found = c;
        end
        return found;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // cycle model
    int m_busy = 0, m_idx = 0, m_c = 0, m_b2b = 0, m_poked = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_idx = 0; m_c = 0; m_b2b = 0; m_poked = 0;
        end else if (start && (m_busy == 0 || m_idx == 0)) begin
            m_b2b   = m_busy;
            m_busy  = 1; m_idx = 3; m_poked = 0;
            m_c     = ref_mul(int'(mcand), int'(mplier));
        end else if (m_busy != 0) begin
            if (start) m_poked = 1;
            m_b2b = 0;
            if (m_idx == 0) m_busy = 0;
            else            m_idx--;
        end
    end

    int got = 0;
    always @(negedge clk) begin
        int e_idx, e_done, e_bit;
        string tv, tb_tag;
        e_idx  = (m_busy != 0) ? m_idx : 0;
        e_done = (m_busy != 0 && m_idx == 0) ? 1 : 0;
        e_bit  = (m_busy != 0) ? dual_bit(m_c, m_idx) : 0;
        tv     = !rst_n ? "R1" : (m_b2b != 0 ? "R7" : (m_busy != 0 ? "R2" : "R8"));
        tb_tag = !rst_n ? "R1" : (m_poked != 0 ? "R6" : (m_busy != 0 ? "R4" : "R8"));
        chk(prod_valid == (m_busy != 0), tv, "valid", int'(prod_valid), m_busy);
        chk(int'(prod_idx) == e_idx, tv, "idx", int'(prod_idx), e_idx);
        chk(int'(prod_done) == e_done, (m_busy != 0) ? "R3" : tv, "done", int'(prod_done), e_done);
        chk(int'(prod_bit) == e_bit, tb_tag, "bit", int'(prod_bit), e_bit);
        if (rst_n && prod_valid) begin
            if (prod_bit) got |= (1 << prod_idx);
            else          got &= ~(1 << prod_idx);
            if (prod_done) begin
                // R4 R5: assembled product mapped back to polynomial form
                chk(dual_to_poly(got) == m_c, "R4 R5", "product", dual_to_poly(got), m_c);
            end
        end
    end

    task automatic run_pair(input int a, input int b, input int gap, input bit poke);
        start = 1'b1; mcand = 4'(a); mplier = 4'(b);
        @(negedge clk);
        start = 1'b0; mcand = ~4'(a); mplier = ~4'(b);
        @(negedge clk);
        if (poke) start = 1'b1;
        @(negedge clk);
        start = 1'b0; mcand = 4'(a + 5); mplier = 4'(b + 3);
        @(negedge clk);
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle right after reset
        chk(!prod_valid && !prod_done && !prod_bit && prod_idx == 2'd0, "R1", "idle", int'(prod_valid), 0);
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_pair(a, b, (a + b) % 3, b[0]);
        start = 1'b0;
        repeat (6) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule